// File: doc/BRIEF.md
# ECP Host Register Front End

This block sits between the host bus and the rest of an ECP-capable parallel port. It decodes single-cycle host reads and writes at offsets from the port base into three groups of registers. The first group is the data, status and control registers. The second is an index/data window that reaches a small bank of extended control registers. The third is a sticky EPP time-out flag, which sits in bit 0 of the status byte. The FIFO, the line handshake engine and the time-out timer are outside the block. The timer reports a time-out as a one-cycle pulse.

Access depends on the port's operating state. When ECP operation is on, the ECP data register takes the place of the legacy data register, and it is reachable only while the 3-bit mode field selects one of the two plain modes. A read of the ECP data register returns the live data pins. The extended window opens only when its enable input is set and the base address has bit 2 or bit 10 set. A blocked or unmapped access changes nothing and reads as 00h. Read data is registered and appears on the cycle after the read strobe.

Top module: `ecp_host_regs`

## Requirements
- R1: After reset the data latch, control register, index register and all extended registers are 00h, host_rdata is 00h, and the time-out flag is 1.
- R2: With ECP operation off, a write to offset 000h loads pd_out, and a read of 000h returns the latched value, not the pins.
- R3: With ECP operation on and mode 000 or 001, a write to 000h loads pd_out, and a read of 000h returns pd_in.
- R4: With ECP operation on and any other mode, writes to 000h leave pd_out unchanged, and reads of 000h return 00h.
- R5: The status register at 001h is read-only: writes to it change nothing. Its bits 2 and 1 always read as 1.
- R6: Status bits 7..3 show prn_stat[4:0] (bit 7 = prn_stat[4], down to bit 3 = prn_stat[0]) after a two-flop synchronizer. A pin change is visible to a read issued two cycles later.
- R7: When the mode field is not 100 (EPP), status bit 0 reads as 1.
- R8: In EPP mode (mode 100), the flag is cleared on entry to the mode and set by a tmo_pulse. It is cleared by a read of 001h. When a pulse and a read fall in the same cycle, the read returns the old value and the flag ends up set.
- R9: Offset 403h holds the window index and reads back. Offset 404h reads and writes the extended register the index selects. The implemented indices are 00h, 02h, 04h and 05h, which appear on xreg_out bytes 0, 1, 2 and 3.
- R10: Through 404h, an unimplemented index reads 00h, and writes to it change no extended register.
- R11: The window is open only when xreg_en is 1 and base_addr bit 2 or bit 10 is 1. Otherwise, writes to 403h and 404h are ignored and reads of them return 00h.
- R12: The control register at 002h is readable and writable in every mode and drives ctl_out.
- R13: host_rdata changes only on the clock edge that follows a cycle with host_rd high, and holds otherwise.
- R14: Reads of unmapped offsets return 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_off | input | OFF_W | Register offset from the port base |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| ecp_on | input | 1 | ECP operation enabled |
| ecr_mode | input | 3 | Mode field (100 = EPP) |
| xreg_en | input | 1 | Extended window enable |
| base_addr | input | BASE_W | Port base address |
| pd_in | input | 8 | Live data pin values |
| pd_out | output | 8 | Latched data to the pins |
| ctl_out | output | 8 | Control register contents |
| prn_stat | input | 5 | Printer status pins, busy down to error |
| tmo_pulse | input | 1 | Time-out event from the EPP timer |
| xreg_out | output | 32 | Extended registers, byte i = i-th implemented index |

## Verification
The bench uses the default parameters. An 11-bit offset makes the window at 403h and 404h reachable. A 16-bit base address lets the gate be opened through bit 2 (03BCh) and through bit 10 (0400h), and closed with 0378h. The synchronizer depth of two sets the wait before status pins are read back. That wait lets the bench check the time-out flag sequence across mode entry, exit and re-entry, including a pulse that arrives in the same cycle as a read.

// File: rtl/ecp_regs_pkg.sv
// Package: shared constants for the ECP host register front end.
// Assumes host offsets are at least 11 bits wide so the window offsets fit.
package ecp_regs_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_XREG = 4;
    localparam int STAT_W   = 5;

    // Implemented extended indices, in the order they appear on xreg_out.
    localparam logic [BYTE_W-1:0] XREG_IDX [NUM_XREG] = '{8'h00, 8'h02, 8'h04, 8'h05};

    localparam logic [10:0] OFF_DATA = 11'h000;
    localparam logic [10:0] OFF_STAT = 11'h001;
    localparam logic [10:0] OFF_CTL  = 11'h002;
    localparam logic [10:0] OFF_XIDX = 11'h403;
    localparam logic [10:0] OFF_XDAT = 11'h404;

    localparam logic [2:0] MODE_PLAIN0 = 3'b000;
    localparam logic [2:0] MODE_PLAIN1 = 3'b001;
    localparam logic [2:0] MODE_EPP    = 3'b100;
endpackage

// File: rtl/ecp_pin_sync.sv
// Module: multi-stage synchronizer for asynchronous status pins.
// Assumes each pin is a level that stays stable longer than STAGES cycles.
module ecp_pin_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // First stage: capture the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Later stage: pass along the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/ecp_tmo_flag.sv
// Module: sticky EPP time-out flag shown in status bit 0.
// Assumes tmo_pulse is a single-cycle event and stat_rd marks a status read.
// A pulse wins over a same-cycle clear, so no event is lost.
module ecp_tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic epp_mode,
    input  logic tmo_pulse,
    input  logic stat_rd,
    output logic flag_rd
);
    logic flag_q;
    logic epp_prev_q;

    // Track the mode so that entry into EPP can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) epp_prev_q <= 1'b0;
        else        epp_prev_q <= epp_mode;
    end

    // Set on a time-out; clear on EPP entry or on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b1;
        else if (epp_mode && tmo_pulse)
            flag_q <= 1'b1;
        else if (epp_mode && (!epp_prev_q || stat_rd))
            flag_q <= 1'b0;
    end

    assign flag_rd = epp_mode ? flag_q : 1'b1;

    p_tmo_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_mode && tmo_pulse) |=> flag_q);
    p_tmo_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_mode && stat_rd && !tmo_pulse) |=> !flag_q);
    p_tmo_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_mode && !epp_prev_q && !tmo_pulse) |=> !flag_q);
endmodule

// File: rtl/ecp_xreg_bank.sv
// Module: index register plus a bank of extended control registers.
// Assumes win_ok already folds in the enable and the base-address gate.
// Unimplemented indices read as zero and ignore writes.
module ecp_xreg_bank
    import ecp_regs_pkg::*;
#(
    parameter int NUM = NUM_XREG
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win_ok,
    input  logic                  idx_wr,
    input  logic                  dat_wr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     idx_q,
    output logic [BYTE_W-1:0]     dat_rd,
    output logic [NUM*BYTE_W-1:0] xregs
);
    logic [BYTE_W-1:0] bank [NUM];
    logic              hit;

    // Index register: written only through an open window.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (idx_wr && win_ok) idx_q <= wdata;
    end

    genvar g;
    generate
        for (g = 0; g < NUM; g++) begin : g_xreg
            // One extended register, written when the index selects it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank[g] <= '0;
                else if (dat_wr && win_ok && idx_q == XREG_IDX[g])
                    bank[g] <= wdata;
            end
            assign xregs[g*BYTE_W +: BYTE_W] = bank[g];
        end
    endgenerate

    // Read mux: selected register, or zero for an unimplemented index.
    always_comb begin
        dat_rd = '0;
        hit    = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (idx_q == XREG_IDX[i]) begin
                dat_rd = bank[i];
                hit    = 1'b1;
            end
        end
    end

    p_blk_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && !win_ok) |=> $stable(idx_q));
    p_blk_dat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !win_ok) |=> $stable(xregs));
    p_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !hit) |=> $stable(xregs));
endmodule

// File: rtl/ecp_host_regs.sv
// Module: host register front end of an ECP-capable parallel port.
// Decodes data, status, control and the extended index/data window.
// Assumes host_wr and host_rd are never high in the same cycle.
// Read data is registered; blocked or unmapped reads return zero.
module ecp_host_regs
    import ecp_regs_pkg::*;
#(
    parameter int OFF_W       = 11,
    parameter int BASE_W      = 16,
    parameter int SYNC_STAGES = 2,
    localparam int XW         = NUM_XREG * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              ecp_on,
    input  logic [2:0]        ecr_mode,
    input  logic              xreg_en,
    input  logic [BASE_W-1:0] base_addr,
    input  logic [BYTE_W-1:0] pd_in,
    output logic [BYTE_W-1:0] pd_out,
    output logic [BYTE_W-1:0] ctl_out,
    input  logic [STAT_W-1:0] prn_stat,
    input  logic              tmo_pulse,
    output logic [XW-1:0]     xreg_out
);
    logic              sel_data, sel_stat, sel_ctl, sel_xidx, sel_xdat;
    logic              data_ok, win_ok, epp_mode, tmo_bit;
    logic [STAT_W-1:0] stat_sync;
    logic [BYTE_W-1:0] xidx_q, xdat_rd, rd_val, status_byte;

    assign sel_data = host_off == OFF_W'(OFF_DATA);
    assign sel_stat = host_off == OFF_W'(OFF_STAT);
    assign sel_ctl  = host_off == OFF_W'(OFF_CTL);
    assign sel_xidx = host_off == OFF_W'(OFF_XIDX);
    assign sel_xdat = host_off == OFF_W'(OFF_XDAT);

    assign data_ok  = !ecp_on || ecr_mode == MODE_PLAIN0 || ecr_mode == MODE_PLAIN1;
    assign win_ok   = xreg_en && (base_addr[2] || base_addr[10]);
    assign epp_mode = ecr_mode == MODE_EPP;

    ecp_pin_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (prn_stat),
        .dout (stat_sync)
    );

    ecp_tmo_flag u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .epp_mode (epp_mode),
        .tmo_pulse(tmo_pulse),
        .stat_rd  (host_rd && sel_stat),
        .flag_rd  (tmo_bit)
    );

    ecp_xreg_bank #(.NUM(NUM_XREG)) u_xbank (
        .clk   (clk),
        .rst_n (rst_n),
        .win_ok(win_ok),
        .idx_wr(host_wr && sel_xidx),
        .dat_wr(host_wr && sel_xdat),
        .wdata (host_wdata),
        .idx_q (xidx_q),
        .dat_rd(xdat_rd),
        .xregs (xreg_out)
    );

    assign status_byte = {stat_sync, 2'b11, tmo_bit};

    // Data latch: written only when the data register is reachable.
    always_ff @(posedge clk) begin
        if (!rst_n)                           pd_out <= '0;
        else if (host_wr && sel_data && data_ok) pd_out <= host_wdata;
    end

    // Control register: writable in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctl_out <= '0;
        else if (host_wr && sel_ctl) ctl_out <= host_wdata;
    end

    // Read mux: pick the value for the addressed register.
    always_comb begin
        rd_val = '0;
        if (sel_data && data_ok)      rd_val = ecp_on ? pd_in : pd_out;
        else if (sel_stat)            rd_val = status_byte;
        else if (sel_ctl)             rd_val = ctl_out;
        else if (sel_xidx && win_ok)  rd_val = xidx_q;
        else if (sel_xdat && win_ok)  rd_val = xdat_rd;
    end

    // Read data register: updated only by a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_val;
    end

    p_blocked_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel_data && ecp_on && ecr_mode[2:1] != 2'b00) |=> $stable(pd_out));
    p_stat_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sel_stat) |=> host_rdata[2:1] == 2'b11);
    p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
    p_nonepp_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sel_stat && !epp_mode) |=> host_rdata[0]);
endmodule

// File: tb/ecp_host_regs_bench.sv
module ecp_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [10:0] host_off = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        ecp_on = 1'b0;
    logic [2:0]  ecr_mode = 3'b000;
    logic        xreg_en = 1'b0;
    logic [15:0] base_addr = 16'h0378;
    logic [7:0]  pd_in = '0;
    logic [7:0]  pd_out, ctl_out;
    logic [4:0]  prn_stat = '0;
    logic        tmo_pulse = 1'b0;
    logic [31:0] xreg_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ecp_host_regs u_ecp_host_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ecp_on(ecp_on), .ecr_mode(ecr_mode), .xreg_en(xreg_en),
        .base_addr(base_addr), .pd_in(pd_in), .pd_out(pd_out),
        .ctl_out(ctl_out), .prn_stat(prn_stat), .tmo_pulse(tmo_pulse),
        .xreg_out(xreg_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] off, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_off = off; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] off, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_off = off;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pd_out", {24'h0, pd_out}, 32'h00);
        chk("R1 ctl_out", {24'h0, ctl_out}, 32'h00);
        chk("R1 xreg_out", xreg_out, 32'h0);
        chk("R1 rdata", {24'h0, host_rdata}, 32'h00);
        rd(11'h001, v);
        chk("R1 R5 status", {24'h0, v}, 32'h07);
    endtask

    task automatic t_legacy_data();
        logic [7:0] v;
        ecp_on = 1'b0; pd_in = 8'hA5;
        wr(11'h000, 8'h3C);
        chk("R2 pd_out", {24'h0, pd_out}, 32'h3C);
        rd(11'h000, v);
        chk("R2 read latch", {24'h0, v}, 32'h3C);
    endtask

    task automatic t_ecp_data();
        logic [7:0] v;
        ecp_on = 1'b1; ecr_mode = 3'b001;
        wr(11'h000, 8'h5A);
        chk("R3 pd_out", {24'h0, pd_out}, 32'h5A);
        rd(11'h000, v);
        chk("R3 read pins mode1", {24'h0, v}, 32'hA5);
        ecr_mode = 3'b000;
        rd(11'h000, v);
        chk("R3 read pins mode0", {24'h0, v}, 32'hA5);
    endtask

    task automatic t_blocked_data();
        logic [7:0] v;
        ecr_mode = 3'b011;
        wr(11'h000, 8'hFF);
        chk("R4 pd_out kept", {24'h0, pd_out}, 32'h5A);
        rd(11'h000, v);
        chk("R4 read zero", {24'h0, v}, 32'h00);
        ecr_mode = 3'b000;
    endtask

    task automatic t_status();
        logic [7:0] v;
        wr(11'h001, 8'h00);
        rd(11'h001, v);
        chk("R5 write ignored", {24'h0, v}, 32'h07);
        @(negedge clk);
        prn_stat = 5'b10110;
        repeat (3) @(negedge clk);
        rd(11'h001, v);
        chk("R6 pins", {24'h0, v}, 32'hB7);
        prn_stat = 5'b01001;
        repeat (3) @(negedge clk);
        rd(11'h001, v);
        chk("R6 pins alt", {24'h0, v}, 32'h4F);
    endtask

    task automatic t_tmo();
        logic [7:0] v;
        @(negedge clk); tmo_pulse = 1'b1;
        @(negedge clk); tmo_pulse = 1'b0;
        rd(11'h001, v);
        chk("R7 non-EPP bit0", {31'h0, v[0]}, 32'h1);
        ecr_mode = 3'b100;
        @(negedge clk);
        rd(11'h001, v);
        chk("R8 cleared on entry", {31'h0, v[0]}, 32'h0);
        @(negedge clk); tmo_pulse = 1'b1;
        @(negedge clk); tmo_pulse = 1'b0;
        rd(11'h001, v);
        chk("R8 set by pulse", {31'h0, v[0]}, 32'h1);
        rd(11'h001, v);
        chk("R8 cleared by read", {31'h0, v[0]}, 32'h0);
        @(negedge clk);
        host_rd = 1'b1; host_off = 11'h001; tmo_pulse = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; tmo_pulse = 1'b0;
        chk("R8 same-cycle old value", {31'h0, host_rdata[0]}, 32'h0);
        rd(11'h001, v);
        chk("R8 same-cycle pulse kept", {31'h0, v[0]}, 32'h1);
        ecr_mode = 3'b000;
        @(negedge clk); tmo_pulse = 1'b1;
        @(negedge clk); tmo_pulse = 1'b0;
        ecr_mode = 3'b100;
        @(negedge clk);
        rd(11'h001, v);
        chk("R8 re-entry clears", {31'h0, v[0]}, 32'h0);
        ecr_mode = 3'b000;
    endtask

    task automatic t_ctl();
        logic [7:0] v;
        ecr_mode = 3'b011;
        wr(11'h002, 8'h2C);
        chk("R12 ctl_out", {24'h0, ctl_out}, 32'h2C);
        rd(11'h002, v);
        chk("R12 read", {24'h0, v}, 32'h2C);
        ecr_mode = 3'b000;
    endtask

    task automatic t_xwin();
        logic [7:0] v;
        xreg_en = 1'b1; base_addr = 16'h03BC;
        wr(11'h403, 8'h02);
        wr(11'h404, 8'h77);
        rd(11'h404, v);
        chk("R9 data read", {24'h0, v}, 32'h77);
        rd(11'h403, v);
        chk("R9 index read", {24'h0, v}, 32'h02);
        wr(11'h403, 8'h05);
        wr(11'h404, 8'h99);
        wr(11'h403, 8'h00);
        wr(11'h404, 8'h11);
        wr(11'h403, 8'h04);
        wr(11'h404, 8'h44);
        chk("R9 xreg_out map", xreg_out, 32'h99447711);
        wr(11'h403, 8'h03);
        wr(11'h404, 8'h55);
        rd(11'h404, v);
        chk("R10 unimpl read", {24'h0, v}, 32'h00);
        chk("R10 unimpl write", xreg_out, 32'h99447711);
    endtask

    task automatic t_gate();
        logic [7:0] v;
        xreg_en = 1'b0;
        wr(11'h403, 8'h04);
        rd(11'h403, v);
        chk("R11 blocked read", {24'h0, v}, 32'h00);
        wr(11'h404, 8'hEE);
        chk("R11 blocked write", xreg_out, 32'h99447711);
        xreg_en = 1'b1; base_addr = 16'h0400;
        rd(11'h403, v);
        chk("R11 index kept bit10", {24'h0, v}, 32'h03);
        base_addr = 16'h0378;
        wr(11'h403, 8'h00);
        wr(11'h404, 8'hEE);
        chk("R11 base gate write", xreg_out, 32'h99447711);
        rd(11'h404, v);
        chk("R11 base gate read", {24'h0, v}, 32'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(11'h100, 8'hAA);
        rd(11'h100, v);
        chk("R14 read zero", {24'h0, v}, 32'h00);
        chk("R14 no side effect", {16'h0, pd_out, ctl_out}, {16'h0, 8'h5A, 8'h2C});
    endtask

    task automatic t_hold();
        logic [7:0] v;
        rd(11'h002, v);
        host_off = 11'h001;
        repeat (4) @(negedge clk);
        chk("R13 hold", {24'h0, host_rdata}, 32'h2C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legacy_data();
        t_ecp_data();
        t_blocked_data();
        t_status();
        t_tmo();
        t_ctl();
        t_xwin();
        t_gate();
        t_unmapped();
        t_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule